// File: doc/BRIEF.md
# Microprogram Sequencer for a Single-Bus Datapath

This block is the control unit of a simple single-bus processor. A microprogram address register selects one word of an internal control store, and that word is driven out unchanged as the control vector. Each bit of the vector enables one datapath action: a register driving the bus, a register loading from the bus, an ALU operation, or a memory request. The block also advances itself. It steps through the instruction fetch, jumps to the routine for the fetched opcode, can branch on a condition flag, stalls while memory is busy, and returns to fetch when a routine finishes.

The surrounding datapath is outside the block: registers, ALU and memory. The datapath feeds three things back into the sequencer: the opcode of the instruction, a small set of condition flags, and a memory-done strobe. The opcode input is sampled at the end of the step that loads the instruction register, so it must present the opcode being loaded in that step, which is the instruction register's data input.

Two routines are stored:
- **Add from memory** (opcode 1) adds the memory word addressed by R3 into R1.
- **Jump on flag** (opcode 2) copies R3 into the program counter when flag bit 2 is set.

Top module: `useq_ctrl`

## Requirements
- R1: The reset input `rst_n` is active low and takes effect immediately, even in the middle of a memory stall. While it is low and after it is released, `ctrl_o` shows the first fetch word. Release is synchronized over two clock edges before the sequencer advances.
- R2: `ctrl_o` bit positions are as follows:
  - 0: PC drives the bus
  - 1: PC loads
  - 2: MAR loads
  - 3: MDR drives the bus
  - 4: IR loads
  - 5: Y loads
  - 6: R1 loads
  - 7: R1 drives the bus
  - 8: R3 drives the bus
  - 9: Z loads
  - 10: Z drives the bus
  - 11: Y is forced to zero at the ALU
  - 12: carry-in
  - 13: add
  - 14: memory read
  - 15: wait for memory
  - 16: routine end

  The fetch is three words: 0x07A05, then 0x08402, then 0x00018. Together they increment PC through the ALU.
- R3: While a word with bit 15 set is shown and `mem_done_i` is low, the word is held. Each cycle of memory latency adds exactly one held cycle.
- R4: After a word with bit 16 set, the next word is the first fetch word 0x07A05.
- R5: At the end of the third fetch word, the next address comes from the opcode. Opcode 1 starts the add routine and opcode 2 starts the jump-on-flag routine.
- R6: Any other opcode, including 0, returns straight to the first fetch word. Only the PC changes.
- R7: The jump-on-flag routine spends one decision step and then one final step. When `flags_i[2]` is 1 the final word is 0x10102 (R3 into PC). Otherwise the final word is 0x10000. The other flag bits have no effect.
- R8: The add routine words are 0x04104, 0x080A0, 0x02208 and 0x10440, in that order.
- R9: One add instruction leaves R1 = R1 + mem[R3] and PC = PC + 1. It takes 7 + 2L cycles for memory latency L.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode_i | input | 4 | Opcode being loaded into the instruction register |
| flags_i | input | 4 | Condition flags tested by microbranches |
| mem_done_i | input | 1 | Memory function complete |
| ctrl_o | output | 17 | Control word for the current microstep |

## Verification
The memory wait and the step advance can meet in one cycle. When memory latency is zero, completion is already signalled in the very cycle the waiting word first appears, and the sequencer must move on without a held cycle. The bench runs the same add and fetch sequences at latencies 0, 1 and 3, and compares the full word trace and the cycle count against 7 + 2L. A held cycle too many or too few breaks both the trace and the final register values.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int UPC_W  = 4;
  localparam int OP_W   = 4;
  localparam int FLAG_W = 4;
  localparam int CSEL_W = $clog2(FLAG_W);
  localparam int NCTRL  = 17;
  localparam int DEPTH  = 1 << UPC_W;

  // control bit positions
  localparam int C_PC_DRV  = 0;
  localparam int C_PC_LD   = 1;
  localparam int C_MAR_LD  = 2;
  localparam int C_MDR_DRV = 3;
  localparam int C_IR_LD   = 4;
  localparam int C_Y_LD    = 5;
  localparam int C_R1_LD   = 6;
  localparam int C_R1_DRV  = 7;
  localparam int C_R3_DRV  = 8;
  localparam int C_Z_LD    = 9;
  localparam int C_Z_DRV   = 10;
  localparam int C_Y_ZERO  = 11;
  localparam int C_CIN     = 12;
  localparam int C_ADD     = 13;
  localparam int C_RD      = 14;
  localparam int C_WAIT    = 15;
  localparam int C_LAST    = 16;

  // routine entry points
  localparam logic [UPC_W-1:0] A_FETCH = 4'd0;
  localparam logic [UPC_W-1:0] A_ADDM  = 4'd3;
  localparam logic [UPC_W-1:0] A_JMPF  = 4'd7;
  localparam logic [UPC_W-1:0] A_JNO   = 4'd8;
  localparam logic [UPC_W-1:0] A_JYES  = 4'd9;

  localparam logic [OP_W-1:0]   OP_ADDM = 4'd1;
  localparam logic [OP_W-1:0]   OP_JMPF = 4'd2;
  localparam logic [CSEL_W-1:0] JMP_FLAG = 2'd2;

  typedef struct packed {
    logic [NCTRL-1:0]  ctrl;
    logic              dispatch;
    logic              br_en;
    logic [CSEL_W-1:0] csel;
    logic [UPC_W-1:0]  tgt;
  } uword_t;
endpackage

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
(
  input  logic [UPC_W-1:0] addr,
  output uword_t           word
);
  function automatic logic [NCTRL-1:0] bits(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d);
    logic [NCTRL-1:0] v;
    v = '0;
    if (a < NCTRL) v[a] = 1'b1;
    if (b < NCTRL) v[b] = 1'b1;
    if (c < NCTRL) v[c] = 1'b1;
    if (d < NCTRL) v[d] = 1'b1;
    return v;
  endfunction

  localparam int unsigned NO = NCTRL;

  always_comb begin
    word = '0;
    unique case (addr)
      4'd0: word.ctrl = bits(C_PC_DRV, C_MAR_LD, C_RD, C_Z_LD)
                      | bits(C_Y_ZERO, C_CIN, C_ADD, NO);
      4'd1: word.ctrl = bits(C_Z_DRV, C_PC_LD, C_WAIT, NO);
      4'd2: begin
        word.ctrl     = bits(C_MDR_DRV, C_IR_LD, NO, NO);
        word.dispatch = 1'b1;
      end
      4'd3: word.ctrl = bits(C_R3_DRV, C_MAR_LD, C_RD, NO);
      4'd4: word.ctrl = bits(C_R1_DRV, C_Y_LD, C_WAIT, NO);
      4'd5: word.ctrl = bits(C_MDR_DRV, C_ADD, C_Z_LD, NO);
      4'd6: word.ctrl = bits(C_Z_DRV, C_R1_LD, C_LAST, NO);
      4'd7: begin
        word.br_en = 1'b1;
        word.csel  = JMP_FLAG;
        word.tgt   = A_JYES;
      end
      4'd8: word.ctrl = bits(C_LAST, NO, NO, NO);
      4'd9: word.ctrl = bits(C_R3_DRV, C_PC_LD, C_LAST, NO);
      default: word.ctrl = bits(C_LAST, NO, NO, NO);
    endcase
  end
endmodule

// File: rtl/useq_start.sv
module useq_start
  import useq_pkg::*;
#(
  parameter int NMAP = 2
) (
  input  logic [OP_W-1:0]  opcode,
  output logic             hit,
  output logic [UPC_W-1:0] entry
);
  localparam logic [OP_W-1:0]  MAP_OP [NMAP] = '{OP_ADDM, OP_JMPF};
  localparam logic [UPC_W-1:0] MAP_AD [NMAP] = '{A_ADDM, A_JMPF};

  logic [NMAP-1:0] match;

  for (genvar i = 0; i < NMAP; i++) begin : g_map
    assign match[i] = (opcode == MAP_OP[i]);
  end

  always_comb begin
    hit   = 1'b0;
    entry = A_FETCH;
    for (int i = 0; i < NMAP; i++) begin
      if (match[i]) begin
        hit   = 1'b1;
        entry = MAP_AD[i];
      end
    end
  end
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
(
  input  logic [UPC_W-1:0]  upc,
  input  uword_t            word,
  input  logic [FLAG_W-1:0] flags,
  input  logic              mem_done,
  input  logic              map_hit,
  input  logic [UPC_W-1:0]  map_entry,
  output logic              adv,
  output logic [UPC_W-1:0]  upc_nxt
);
  assign adv = !(word.ctrl[C_WAIT] && !mem_done);

  always_comb begin
    if (word.ctrl[C_LAST])
      upc_nxt = A_FETCH;
    else if (word.dispatch)
      upc_nxt = map_hit ? map_entry : A_FETCH;
    else if (word.br_en && flags[word.csel])
      upc_nxt = word.tgt;
    else
      upc_nxt = upc + 1'b1;
  end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   opcode_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic              mem_done_i,
  output logic [NCTRL-1:0]  ctrl_o
);
  logic [1:0]       rst_q;
  logic             srst_n;
  logic [UPC_W-1:0] upc;
  logic [UPC_W-1:0] upc_nxt;
  logic             adv;
  logic             map_hit;
  logic [UPC_W-1:0] map_entry;
  uword_t           word;

  // reset asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign srst_n = rst_q[1];

  useq_store u_store (.addr(upc), .word(word));

  useq_start #(.NMAP(2)) u_start (
    .opcode(opcode_i), .hit(map_hit), .entry(map_entry)
  );

  useq_next u_next (
    .upc(upc), .word(word), .flags(flags_i), .mem_done(mem_done_i),
    .map_hit(map_hit), .map_entry(map_entry), .adv(adv), .upc_nxt(upc_nxt)
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)  upc <= A_FETCH;
    else if (adv) upc <= upc_nxt;
  end

  assign ctrl_o = word.ctrl;
endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk
  import useq_pkg::*;
(
  input logic              clk,
  input logic              srst_n,
  input logic [UPC_W-1:0]  upc,
  input logic [NCTRL-1:0]  ctrl_o,
  input logic [FLAG_W-1:0] flags_i,
  input logic              mem_done_i
);
  // R3: a waiting word without completion keeps its address
  a_r3_wait_holds: assert property (@(posedge clk) disable iff (!srst_n)
    (ctrl_o[C_WAIT] && !mem_done_i) |=> (upc == $past(upc)));

  // R4: a final word returns to fetch
  a_r4_end_to_fetch: assert property (@(posedge clk) disable iff (!srst_n)
    (ctrl_o[C_LAST] && !ctrl_o[C_WAIT]) |=> (upc == A_FETCH));

  // R2: the first fetch word always moves to the second
  a_r2_fetch_steps: assert property (@(posedge clk) disable iff (!srst_n)
    (upc == A_FETCH) |=> (upc == A_FETCH + 1'b1));

  // R5 / R6: after the instruction load only a routine entry or fetch follows
  a_r5_dispatch_target: assert property (@(posedge clk) disable iff (!srst_n)
    ctrl_o[C_IR_LD] |=> (upc == A_ADDM || upc == A_JMPF || upc == A_FETCH));

  // R7: decision step follows flag bit 2
  a_r7_jump_taken: assert property (@(posedge clk) disable iff (!srst_n)
    (upc == A_JMPF && flags_i[JMP_FLAG]) |=> (upc == A_JYES));
  a_r7_jump_not_taken: assert property (@(posedge clk) disable iff (!srst_n)
    (upc == A_JMPF && !flags_i[JMP_FLAG]) |=> (upc == A_JNO));
endmodule

bind useq_ctrl useq_ctrl_chk u_chk (
  .clk(clk), .srst_n(srst_n), .upc(upc), .ctrl_o(ctrl_o),
  .flags_i(flags_i), .mem_done_i(mem_done_i)
);

// File: tb/sim_useq_ctrl.sv
`timescale 1ns/1ps
module sim_useq_ctrl;
  localparam logic [16:0] F1 = 17'h07A05, F2 = 17'h08402, F3 = 17'h00018;
  localparam logic [16:0] D1 = 17'h04104, D2 = 17'h080A0, D3 = 17'h02208, D4 = 17'h10440;
  localparam logic [16:0] JN = 17'h10000, JY = 17'h10102, J0 = 17'h00000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  opcode_i;
  logic [3:0]  flags_i;
  logic        mem_done_i;
  logic [16:0] ctrl_o;

  always #2.5 clk = ~clk;

  useq_ctrl u0 (.clk(clk), .rst_n(rst_n), .opcode_i(opcode_i), .flags_i(flags_i),
                .mem_done_i(mem_done_i), .ctrl_o(ctrl_o));

  int n_run = 0, n_fail = 0;
  logic [15:0] pc, mar, mdr, ir, y, z, r1, r3;
  logic [15:0] mem [64];
  logic        pend;
  int          cnt, lat;
  logic [5:0]  maddr;
  logic [16:0] cw;
  logic [16:0] trace [64];
  int          ntr;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock of the modelled datapath and memory
  task automatic cyc();
    logic [15:0] bus, alu;
    @(negedge clk);
    cw = ctrl_o;
    mem_done_i = pend && (cnt == 0);
    opcode_i = cw[4] ? mdr[3:0] : ir[3:0];
    bus = 16'h0;
    if (cw[0])  bus = pc;
    if (cw[3])  bus = mdr;
    if (cw[7])  bus = r1;
    if (cw[8])  bus = r3;
    if (cw[10]) bus = z;
    alu = (cw[11] ? 16'h0 : y) + bus + {15'h0, cw[12]};
    @(posedge clk);
    #1;
    if (pend && cnt == 0) begin mdr = mem[maddr]; pend = 1'b0; end
    else if (pend) cnt--;
    if (cw[2]) mar = bus;
    if (cw[14]) begin pend = 1'b1; cnt = lat; maddr = mar[5:0]; end
    if (cw[1]) pc = bus;
    if (cw[4]) ir = bus;
    if (cw[5]) y = bus;
    if (cw[6]) r1 = bus;
    if (cw[9]) z = alu;
    if (ntr < 64) trace[ntr] = cw;
    ntr++;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pend = 1'b0; cnt = 0; mem_done_i = 1'b0; flags_i = 4'h0; opcode_i = 4'h0;
    #7;
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    ntr = 0;
  endtask

  task automatic run_to_end();
    ntr = 0;
    do cyc(); while (!cw[16] && ntr < 60);
  endtask

  task automatic cmp_trace(input string tag, input logic [16:0] exp [64], input int n);
    int bad = -1;
    for (int i = 0; i < n; i++) if (bad < 0 && trace[i] !== exp[i]) bad = i;
    check(ntr == n, {tag, " trace length"}, ntr, n);
    if (bad >= 0) check(1'b0, {tag, " trace word"}, trace[bad], exp[bad]);
    else          check(1'b1, tag, 0, 0);
  endtask

  task automatic t_reset();
    do_reset();
    check(ctrl_o == F1, "R1 word after reset", ctrl_o, F1);
    lat = 6; pc = 0; mem[0] = 16'h1;
    cyc(); cyc(); cyc();
    check(ctrl_o == F2, "R3 held during long latency", ctrl_o, F2);
    #1 rst_n = 1'b0; #1;
    check(ctrl_o == F1, "R1 async reset mid-stall", ctrl_o, F1);
    do_reset();
    check(ctrl_o == F1, "R1 word after re-release", ctrl_o, F1);
  endtask

  task automatic t_add(input int l);
    logic [16:0] e [64];
    int k = 0;
    do_reset(); lat = l;
    pc = 16'd5; mem[5] = 16'h0001; r1 = 16'd100; r3 = 16'd20; mem[20] = 16'd37;
    e[k++] = F1; repeat (l + 1) e[k++] = F2; e[k++] = F3;
    e[k++] = D1; repeat (l + 1) e[k++] = D2; e[k++] = D3; e[k++] = D4;
    run_to_end();
    cmp_trace($sformatf("R2 R8 R5 add sequence lat=%0d", l), e, k);
    check(ntr == 7 + 2 * l, "R3 R9 cycle count", ntr, 7 + 2 * l);
    check(r1 == 16'd137, "R9 R1 sum", r1, 137);
    check(pc == 16'd6, "R9 PC incremented", pc, 6);
    check(ctrl_o == F1, "R4 back to fetch", ctrl_o, F1);
  endtask

  task automatic t_unmapped(input logic [3:0] op);
    logic [16:0] e [64];
    int k = 0;
    do_reset(); lat = 1;
    pc = 16'd9; mem[9] = {12'h0, op}; r1 = 16'd55; r3 = 16'd3;
    e[k++] = F1; repeat (2) e[k++] = F2; e[k++] = F3;
    ntr = 0;
    repeat (k) cyc();
    cmp_trace($sformatf("R6 fetch before opcode %0d", op), e, k);
    check(ctrl_o == F1, "R6 unmapped returns to fetch", ctrl_o, F1);
    check(pc == 16'd10 && r1 == 16'd55, "R6 only PC changes", {pc, r1}, {16'd10, 16'd55});
  endtask

  task automatic t_jump(input logic [3:0] fl, input bit taken);
    logic [16:0] e [64];
    int k = 0;
    do_reset(); lat = 0; flags_i = fl;
    pc = 16'd12; mem[12] = 16'h0002; r3 = 16'd40;
    e[k++] = F1; e[k++] = F2; e[k++] = F3; e[k++] = J0; e[k++] = taken ? JY : JN;
    run_to_end();
    cmp_trace($sformatf("R7 jump flags=%0h", fl), e, k);
    check(pc == (taken ? 16'd40 : 16'd13), "R7 PC after jump", pc, taken ? 40 : 13);
    check(ctrl_o == F1, "R4 fetch after jump", ctrl_o, F1);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'h0;
    mar = 0; mdr = 0; ir = 0; y = 0; z = 0; r1 = 0; r3 = 0; pc = 0; lat = 0; ntr = 0;
    t_reset();
    t_add(0);
    t_add(1);
    t_add(3);
    t_unmapped(4'd0);
    t_unmapped(4'd9);
    t_jump(4'b0100, 1'b1);
    t_jump(4'b1011, 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #500000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule